// File: doc/BRIEF.md
# DMA Descriptor Chain Fetch Engine

This block walks a singly linked list of transfer descriptors kept in main memory. Software builds each descriptor and hands it over by setting an ownership flag. The engine fetches descriptors over a word-wide memory master port. For each descriptor it owns, it starts an external frame data mover with the buffer address and byte length. When the mover finishes, the engine writes a completion status word back and returns ownership of the descriptor to software.

A descriptor takes four aligned 32-bit words. Word 0 (offset 0x0) is control, word 1 (offset 0x4) is the buffer address, word 2 (offset 0x8) is the next-descriptor pointer, and word 3 (offset 0xC) is status. Control bit 31 is the ownership flag: 0 means software owns the descriptor and 1 means the engine owns it. Control bit 30 enables following the next pointer. Control bit 29 enables polling of a descriptor the engine does not own. Control bits 15:0 hold the frame byte length. The engine writes the status word as follows: bit 31 is a completion flag, always 1; bit 30 copies the mover's error flag; bits 15:0 hold the byte count the mover reports.

The controller has these states:
- IDLE: waiting for work.
- RD_CTRL, RD_BUF, RD_NEXT: reading the three leading words.
- POLL_WAIT: the gap between re-reads.
- XFER_GO: a one-cycle mover start.
- XFER_WAIT: waiting for the mover.
- WR_STAT, WR_CTRL: write-back.
- FINISH: the one-cycle end-of-chain state.
- FAULT: stopped on a misaligned pointer.

The transitions are:
- From IDLE or FAULT, a start goes to RD_CTRL, or to FAULT if the pointer is misaligned.
- From RD_CTRL: an owned descriptor goes to RD_BUF. An unowned descriptor with polling enabled goes to POLL_WAIT. Any other descriptor goes to FINISH.
- POLL_WAIT goes back to RD_CTRL when the gap expires.
- RD_BUF goes to RD_NEXT, then XFER_GO, then XFER_WAIT.
- XFER_WAIT goes to WR_STAT on mover done, then to WR_CTRL.
- From WR_CTRL: with chaining enabled and an aligned next pointer, the engine goes to RD_CTRL at the next pointer. With a misaligned next pointer it goes to FAULT. Otherwise it goes to FINISH.
- FINISH goes to IDLE.

Top module: `desc_chain_engine`

## Requirements
- R1: A start pulse in IDLE or FAULT whose pointer has a nonzero bit 1:0 puts err_o high on the next cycle, with busy_o low and no memory access.
- R2: For an owned descriptor at pointer P, the engine reads P+0, P+4 and P+8, each exactly once, in that order. Every memory address it issues has bits 1:0 equal to zero.
- R3: Once mem_req_o is high, it stays high with the same address, write enable and write data until a cycle with mem_ack_i high completes the access.
- R4: For an owned descriptor, xfer_start_o pulses for exactly one cycle, with xfer_addr_o equal to word 1 and xfer_len_o equal to control bits 15:0. No memory request is active during that pulse.
- R5: After xfer_done_i, the engine writes P+12. The value is bit31=1, bit30=xfer_err_i, bits 15:0=xfer_count_i, and zero in the other bits. It then writes P+0 with the original control word, bit 31 cleared.
- R6: When control bit 30 is 0, the engine finishes after write-back without reading the next pointer's descriptor.
- R7: When control bit 30 is 1 and the next pointer is aligned, the engine processes the descriptor at that pointer next.
- R8: When control bit 31 is 0 and bit 29 is 1, the engine re-reads only P+0. The start cycles of successive re-reads are max(poll_gap_i,1)+1 cycles apart (zero wait-state memory). Once bit 31 reads 1, the engine handles the descriptor normally.
- R9: When control bits 31 and 29 are both 0, the engine finishes with no transfer, no memory write and no further read, whatever bit 30 holds.
- R10: A misaligned next pointer followed after write-back makes err_o high and stops the engine, with no done_o pulse.
- R11: busy_o is high from the cycle after an accepted start until the chain ends. done_o is a single-cycle pulse with busy_o low. While err_o is high, nothing is issued on the memory or mover ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted in IDLE or FAULT |
| first_ptr_i | input | AW | Byte address of the first descriptor |
| poll_gap_i | input | GAP_W | Cycles between poll re-reads (0 acts as 1) |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | One-cycle end-of-chain pulse |
| err_o | output | 1 | Stopped on a misaligned pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge; access completes when req and ack are high |
| xfer_start_o | output | 1 | Frame mover start pulse |
| xfer_addr_o | output | 32 | Frame buffer address |
| xfer_len_o | output | LEN_W | Frame byte length |
| xfer_done_i | input | 1 | Frame mover completion pulse |
| xfer_err_i | input | 1 | Frame mover error, valid with done |
| xfer_count_i | input | LEN_W | Bytes moved, valid with done |

## Verification

The polling case is swept across several gap settings, including zero, and several ownership hand-over points. A wrong gap counter would shift the re-read spacing. A design that re-fetched the whole descriptor while polling would show extra buffer-word reads.

Chains of one to four scattered descriptors run with and without memory wait states. These runs catch a design that reads past the last link, skips the ownership clear, or writes a status word that mixes up the error and count fields.

An unowned descriptor without polling must cause no write at all, even with its chain bit set. Misaligned first and next pointers must stop the engine before it touches memory at the bad address. A design that rounded the pointer down would instead read a neighbouring descriptor.

// File: rtl/dce_pkg.sv
package dce_pkg;

    // Controller states
    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CTRL,
        S_RD_BUF,
        S_RD_NEXT,
        S_POLL_WAIT,
        S_XFER_GO,
        S_XFER_WAIT,
        S_WR_STAT,
        S_WR_CTRL,
        S_FINISH,
        S_FAULT
    } dce_state_e;

    // Word index inside a descriptor; the offset is index * 4
    typedef enum logic [1:0] {
        W_CTRL = 2'd0,
        W_BUF  = 2'd1,
        W_NEXT = 2'd2,
        W_STAT = 2'd3
    } dce_word_e;

    // Control word bit positions
    localparam int CTL_OWN   = 31;
    localparam int CTL_CHAIN = 30;
    localparam int CTL_POLL  = 29;

    // Status word bit positions
    localparam int STS_DONE  = 31;
    localparam int STS_ERR   = 30;

endpackage

// File: rtl/dce_addr_gen.sv
module dce_addr_gen
    import dce_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_i,
    input  dce_word_e     word_i,
    input  logic [AW-1:0] cand_i,
    output logic [AW-1:0] addr_o,
    output logic          cand_ok_o
);

    localparam int HI_W = AW - 4;

    logic [AW-1:0] offset;

    assign offset    = {{HI_W{1'b0}}, word_i, 2'b00};
    assign addr_o    = base_i + offset;
    assign cand_ok_o = (cand_i[1:0] == 2'b00);

endmodule

// File: rtl/dce_gap_timer.sv
module dce_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             expire_o
);

    localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (gap_i == '0) ? ONE : gap_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire_o = (cnt_q == ONE);

endmodule

// File: rtl/dce_desc_regs.sv
module dce_desc_regs
    import dce_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  dce_word_e     word_i,
    input  logic [31:0]   data_i,
    output logic [31:0]   ctrl_o,
    output logic [31:0]   buf_o,
    output logic [AW-1:0] next_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
            buf_o  <= '0;
            next_o <= '0;
        end else if (load_i) begin
            unique case (word_i)
                W_CTRL:  ctrl_o <= data_i;
                W_BUF:   buf_o  <= data_i;
                W_NEXT:  next_o <= data_i[AW-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine
    import dce_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    first_ptr_i,
    input  logic [GAP_W-1:0] poll_gap_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [31:0]      mem_wdata_o,
    input  logic [31:0]      mem_rdata_i,
    input  logic             mem_ack_i,
    output logic             xfer_start_o,
    output logic [31:0]      xfer_addr_o,
    output logic [LEN_W-1:0] xfer_len_o,
    input  logic             xfer_done_i,
    input  logic             xfer_err_i,
    input  logic [LEN_W-1:0] xfer_count_i
);

    localparam int          PAD_W    = 30 - LEN_W;
    localparam logic [31:0] OWN_MASK = ~(32'd1 << CTL_OWN);

    dce_state_e state_q, state_d;

    logic [AW-1:0]    ptr_q;
    logic             stat_err_q;
    logic [LEN_W-1:0] stat_cnt_q;

    logic [31:0]   ctrl_q;
    logic [31:0]   buf_q;
    logic [AW-1:0] next_q;

    dce_word_e     word_sel;
    logic          ack_hit;
    logic          rd_load;
    logic          start_ok;
    logic          next_ok;
    logic          gap_load;
    logic          gap_expire;
    logic          rd_own;
    logic          rd_poll;
    logic [AW-1:0] word_addr;
    logic [31:0]   status_word;

    assign ack_hit  = mem_req_o && mem_ack_i;
    assign rd_load  = ack_hit && !mem_we_o;
    assign rd_own   = mem_rdata_i[CTL_OWN];
    assign rd_poll  = mem_rdata_i[CTL_POLL];
    assign start_ok = (first_ptr_i[1:0] == 2'b00);
    assign gap_load = (state_q == S_RD_CTRL) && ack_hit && !rd_own && rd_poll;

    // Word select follows the state
    always_comb begin
        unique case (state_q)
            S_RD_BUF:  word_sel = W_BUF;
            S_RD_NEXT: word_sel = W_NEXT;
            S_WR_STAT: word_sel = W_STAT;
            default:   word_sel = W_CTRL;
        endcase
    end

    dce_addr_gen #(
        .AW(AW)
    ) i_addr_gen (
        .base_i    (ptr_q),
        .word_i    (word_sel),
        .cand_i    (next_q),
        .addr_o    (word_addr),
        .cand_ok_o (next_ok)
    );

    dce_gap_timer #(
        .GAP_W(GAP_W)
    ) i_gap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (gap_load),
        .gap_i    (poll_gap_i),
        .expire_o (gap_expire)
    );

    dce_desc_regs #(
        .AW(AW)
    ) i_desc_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rd_load),
        .word_i (word_sel),
        .data_i (mem_rdata_i),
        .ctrl_o (ctrl_q),
        .buf_o  (buf_q),
        .next_o (next_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_FAULT: begin
                if (start_i) begin
                    state_d = start_ok ? S_RD_CTRL : S_FAULT;
                end
            end
            S_RD_CTRL: begin
                if (ack_hit) begin
                    if (rd_own) begin
                        state_d = S_RD_BUF;
                    end else if (rd_poll) begin
                        state_d = S_POLL_WAIT;
                    end else begin
                        state_d = S_FINISH;
                    end
                end
            end
            S_POLL_WAIT: begin
                if (gap_expire) begin
                    state_d = S_RD_CTRL;
                end
            end
            S_RD_BUF: begin
                if (ack_hit) begin
                    state_d = S_RD_NEXT;
                end
            end
            S_RD_NEXT: begin
                if (ack_hit) begin
                    state_d = S_XFER_GO;
                end
            end
            S_XFER_GO: begin
                state_d = S_XFER_WAIT;
            end
            S_XFER_WAIT: begin
                if (xfer_done_i) begin
                    state_d = S_WR_STAT;
                end
            end
            S_WR_STAT: begin
                if (ack_hit) begin
                    state_d = S_WR_CTRL;
                end
            end
            S_WR_CTRL: begin
                if (ack_hit) begin
                    if (!ctrl_q[CTL_CHAIN]) begin
                        state_d = S_FINISH;
                    end else if (next_ok) begin
                        state_d = S_RD_CTRL;
                    end else begin
                        state_d = S_FAULT;
                    end
                end
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Pointer and completion capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            stat_err_q <= 1'b0;
            stat_cnt_q <= '0;
        end else begin
            if ((state_q == S_IDLE || state_q == S_FAULT) && start_i) begin
                ptr_q <= first_ptr_i;
            end else if (state_q == S_WR_CTRL && ack_hit && ctrl_q[CTL_CHAIN] && next_ok) begin
                ptr_q <= next_q;
            end
            if (state_q == S_XFER_WAIT && xfer_done_i) begin
                stat_err_q <= xfer_err_i;
                stat_cnt_q <= xfer_count_i;
            end
        end
    end

    always_comb begin
        status_word = {1'b1, stat_err_q, {PAD_W{1'b0}}, stat_cnt_q};
    end

    // Outputs
    always_comb begin
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = word_addr;
        mem_wdata_o  = '0;
        xfer_start_o = 1'b0;
        busy_o       = 1'b1;
        done_o       = 1'b0;
        err_o        = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o = 1'b0;
            end
            S_FAULT: begin
                busy_o = 1'b0;
                err_o  = 1'b1;
            end
            S_FINISH: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            S_RD_CTRL, S_RD_BUF, S_RD_NEXT: begin
                mem_req_o = 1'b1;
            end
            S_WR_STAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = status_word;
            end
            S_WR_CTRL: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = ctrl_q & OWN_MASK;
            end
            S_XFER_GO: begin
                xfer_start_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign xfer_addr_o = buf_q;
    assign xfer_len_o  = ctrl_q[LEN_W-1:0];

endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [1:0]    ptr_lo_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          mem_ack_i,
    input logic          xfer_start_o
);

    // R1
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && !done_o && (ptr_lo_i != 2'b00) |=> err_o && !mem_req_o);

    // R2
    aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));

    // R4
    xfer_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |=> !xfer_start_o);

    // R4
    xfer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> !mem_req_o && busy_o);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !err_o);

    // R10
    err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o && !mem_req_o && !xfer_start_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !xfer_start_o);

endmodule

bind desc_chain_engine dce_checker #(
    .AW(AW)
) i_dce_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ptr_lo_i     (first_ptr_i[1:0]),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .xfer_start_o (xfer_start_o)
);

// File: tb/test_desc_chain_engine.sv
`timescale 1ns/1ps
module test_desc_chain_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] first_ptr_i = '0;
    logic [7:0]  poll_gap_i = 8'd3;
    logic        busy_o, done_o, err_o;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_ack_i = 1'b0;
    logic        xfer_start_o;
    logic [31:0] xfer_addr_o;
    logic [15:0] xfer_len_o;
    logic        xfer_done_i = 1'b0;
    logic        xfer_err_i = 1'b0;
    logic [15:0] xfer_count_i = '0;

    always #4 clk = ~clk;

    desc_chain_engine i_desc_chain_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_ptr_i(first_ptr_i),
        .poll_gap_i(poll_gap_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
        .xfer_start_o(xfer_start_o), .xfer_addr_o(xfer_addr_o), .xfer_len_o(xfer_len_o),
        .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i), .xfer_count_i(xfer_count_i)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [0:63];
    int rd_count [0:63];
    int wr_count [0:63];
    int total_rd, total_wr;
    int lat = 0, wait_cnt = 0, cyc = 0, ix;
    int flip_idx = -1, flip_after = 0, poll_n = 0;
    int poll_t [0:15];
    int xn = 0, mv_cnt = 0;
    logic [31:0] xa [0:7];
    logic [15:0] xl [0:7];
    logic [15:0] mv_len;
    logic        mv_bad;

    // Memory and frame mover models, driven away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (mem_ack_i) begin
            mem_ack_i = 1'b0;
        end else if (mem_req_o) begin
            if (wait_cnt < lat) begin
                wait_cnt++;
            end else begin
                wait_cnt  = 0;
                mem_ack_i = 1'b1;
                ix = int'(mem_addr_o[7:2]);
                if (mem_we_o) begin
                    mem[ix] = mem_wdata_o;
                    wr_count[ix]++;
                    total_wr++;
                end else begin
                    mem_rdata_i = mem[ix];
                    rd_count[ix]++;
                    total_rd++;
                    if (ix == flip_idx) begin
                        if (poll_n < 16) poll_t[poll_n] = cyc;
                        poll_n++;
                        if (poll_n == flip_after) mem[ix][31] = 1'b1;
                    end
                end
            end
        end
        xfer_done_i = 1'b0;
        if (xfer_start_o) begin
            if (xn < 8) begin
                xa[xn] = xfer_addr_o;
                xl[xn] = xfer_len_o;
            end
            mv_bad = (xn % 2 == 1);
            mv_len = xfer_len_o;
            mv_cnt = 2 + xn % 3;
            xn++;
        end else if (mv_cnt > 0) begin
            mv_cnt--;
            if (mv_cnt == 0) begin
                xfer_done_i  = 1'b1;
                xfer_err_i   = mv_bad;
                xfer_count_i = mv_bad ? (mv_len >> 1) : mv_len;
            end
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_env();
        for (int i = 0; i < 64; i++) begin
            mem[i] = '0;
            rd_count[i] = 0;
            wr_count[i] = 0;
        end
        total_rd = 0; total_wr = 0; xn = 0; poll_n = 0;
        flip_idx = -1; flip_after = 0; mv_cnt = 0; lat = 0; wait_cnt = 0;
    endtask

    task automatic run(input logic [31:0] p, output int got_done, output int got_err,
                       output int busy_gap, output int busy_first);
        @(negedge clk);
        first_ptr_i = p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        busy_first = busy_o;
        got_done = 0; got_err = 0; busy_gap = 0;
        for (int t = 0; t < 3000; t++) begin
            if (done_o) begin got_done = 1; break; end
            if (err_o) begin got_err = 1; break; end
            if (!busy_o) busy_gap++;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] daddr(input int k);
        case (k)
            0: return 32'h80;
            1: return 32'h20;
            2: return 32'hA0;
            default: return 32'h40;
        endcase
    endfunction

    function automatic logic [31:0] exp_stat(input int k, input logic [15:0] len);
        logic [15:0] c = (k % 2 == 1) ? (len >> 1) : len;
        return 32'h8000_0000 | ((k % 2 == 1) ? 32'h4000_0000 : 32'h0) | {16'h0, c};
    endfunction

    task automatic chain_test(input int n, input int l);
        logic [31:0] ctl [0:3];
        int gd, ge, bg, bf, w;
        clear_env();
        for (int k = 0; k < n; k++) begin
            w = int'(daddr(k) >> 2);
            ctl[k] = 32'h8000_0000 | ((k < n - 1) ? 32'h4000_0000 : 32'h0)
                   | (32'h100 + 32'h11 * k + n);
            mem[w]     = ctl[k];
            mem[w + 1] = 32'h1000 * (k + 1) + n;
            mem[w + 2] = (k < n - 1) ? daddr(k + 1) : 32'hF0;
            mem[w + 3] = 32'hDEAD_BEEF;
        end
        lat = l;
        run(daddr(0), gd, ge, bg, bf);
        chk(gd == 1 && ge == 0, "R11 chain done", ge, 0);
        chk(bf == 1 && bg == 0, "R11 busy held", bg, 0);
        chk(xn == n, "R7 R6 transfer count", xn, n);
        chk(rd_count[60] == 0, "R6 unlinked word not read", rd_count[60], 0);
        for (int k = 0; k < n; k++) begin
            w = int'(daddr(k) >> 2);
            chk(xa[k] == 32'h1000 * (k + 1) + n, "R4 buffer address", xa[k], 32'h1000 * (k + 1) + n);
            chk(xl[k] == ctl[k][15:0], "R4 length", xl[k], ctl[k][15:0]);
            chk(mem[w + 3] == exp_stat(k, ctl[k][15:0]), "R5 status word", mem[w + 3], exp_stat(k, ctl[k][15:0]));
            chk(mem[w] == (ctl[k] & 32'h7FFF_FFFF), "R5 ownership returned", mem[w], ctl[k] & 32'h7FFF_FFFF);
            chk(rd_count[w] == 1 && rd_count[w + 1] == 1 && rd_count[w + 2] == 1,
                "R2 single fetch of words", rd_count[w + 1], 1);
        end
    endtask

    task automatic poll_test(input int g, input int p);
        int gd, ge, bg, bf, bad, ge_eff;
        clear_env();
        mem[12] = 32'h2000_0000 | (32'h40 + g);
        mem[13] = 32'h2000;
        mem[14] = 32'h0;
        flip_idx = 12;
        flip_after = p;
        poll_gap_i = 8'(g);
        ge_eff = (g == 0) ? 1 : g;
        run(32'h30, gd, ge, bg, bf);
        chk(gd == 1, "R8 poll chain done", gd, 1);
        chk(rd_count[12] == p + 1, "R8 control re-read count", rd_count[12], p + 1);
        chk(rd_count[13] == 1, "R8 buffer word read once", rd_count[13], 1);
        bad = 0;
        for (int i = 0; i < p; i++) begin
            if (poll_t[i + 1] - poll_t[i] != ge_eff + 1) bad++;
        end
        chk(bad == 0, "R8 re-read spacing", poll_t[1] - poll_t[0], ge_eff + 1);
        chk(xn == 1 && xl[0] == 16'(32'h40 + g), "R4 transfer after poll", xn, 1);
        chk(mem[15] == exp_stat(0, 16'(32'h40 + g)), "R5 status after poll", mem[15], exp_stat(0, 16'(32'h40 + g)));
    endtask

    initial begin
        int gd, ge, bg, bf;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !err_o && !mem_req_o && !xfer_start_o,
            "R11 reset state", {busy_o, done_o, err_o, mem_req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 1; n <= 4; n++) begin
            chain_test(n, 0);
            chain_test(n, 2);
        end

        for (int p = 1; p <= 3; p++) begin
            poll_test(0, p);
            poll_test(1, p);
            poll_test(2, p);
            poll_test(3, p);
            poll_test(7, p);
        end

        // R9: unowned, no polling, chain bit set but ignored
        clear_env();
        mem[4] = 32'h4000_0020;
        mem[5] = 32'h3000;
        mem[6] = 32'h80;
        run(32'h10, gd, ge, bg, bf);
        chk(gd == 1 && ge == 0, "R9 ends", gd, 1);
        chk(xn == 0, "R9 no transfer", xn, 0);
        chk(total_wr == 0 && mem[4] == 32'h4000_0020, "R9 no write", total_wr, 0);
        chk(total_rd == 1, "R9 single read", total_rd, 1);

        // R7 / R9: chain stops at an unowned second descriptor
        clear_env();
        mem[8]  = 32'hC000_0010;
        mem[9]  = 32'h5000;
        mem[10] = 32'h50;
        mem[20] = 32'h0000_0033;
        run(32'h20, gd, ge, bg, bf);
        chk(gd == 1 && xn == 1, "R7 follow then R9 stop", xn, 1);
        chk(rd_count[20] == 1 && rd_count[21] == 0 && wr_count[20] == 0,
            "R9 second descriptor untouched", rd_count[21], 0);

        // R1: misaligned first pointer
        clear_env();
        mem[32] = 32'h8000_0010;
        run(32'h82, gd, ge, bg, bf);
        chk(ge == 1 && bf == 0, "R1 error flagged", ge, 1);
        chk(total_rd + total_wr == 0, "R1 no memory access", total_rd + total_wr, 0);

        // R10: misaligned next pointer
        clear_env();
        mem[4] = 32'hC000_0018;
        mem[5] = 32'h6000;
        mem[6] = 32'h36;
        run(32'h10, gd, ge, bg, bf);
        chk(ge == 1 && gd == 0, "R10 error on next", ge, 1);
        chk(xn == 1 && mem[7] == exp_stat(0, 16'h18), "R10 R5 write-back before stop", mem[7], exp_stat(0, 16'h18));
        chk(rd_count[13] == 0 && rd_count[14] == 0 && total_rd == 3, "R10 no fetch at bad pointer", total_rd, 3);

        // R1: restart from the fault state
        chain_test(2, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule